// File: doc/BRIEF.md
# Two-Wire EEPROM Read Master

This block is the host side of a two-wire serial link to an EEPROM organised as 8-bit words. A single command names an access mode, a word address and a word count. The block then produces the whole bus transaction on its own: START and STOP conditions, control bytes, the word address and the acknowledge slots. Each received byte is delivered on a one-clock valid strobe. When the transaction finishes, a one-clock done pulse reports whether it failed and how many bus cycles it used.

Four modes are offered. A selective read sets the device's word pointer to a chosen address and then reads one word. A current-address read takes one word from wherever the device's own pointer stands. Two burst variants read n consecutive words, starting either at a chosen address or at the current pointer. The master acknowledges every word except the last, which gets a NoACK. The cost of each mode is an exact, predictable number of bus cycles, so a caller that streams key or table material can budget its latency.

A bus cycle is one SCL period and lasts `DIV` system clocks. SDA is open-drain: the block only pulls the line low, and it reads the resolved line back on `sda_in`.

Top module: `i2c_eeprom_reader`

## Requirements
- R1: After reset, and whenever no transaction is running: SCL is high, SDA is released (`sda_oe` = 0), `cmd_ready` is 1, and `done`, `err` and `rd_valid` are 0.
- R2: START is SDA falling while SCL is high. STOP is SDA rising while SCL is high. Every other SDA change happens while SCL is low. A control byte is the device address (parameter `DEV_ADDR`, 7 bits, MSB first) followed by a direction bit: 0 when setting the word address, 1 when reading. Address bytes are also sent MSB first.
- R3: Each bus cycle lasts `DIV` clocks, numbered 0 to `DIV`-1. In bit slots SCL is high only in phases 1 to `DIV`-2, and SDA is sampled at the end of phase `DIV`-2.
- R4: Mode 0 (`cmd_mode` = 2'b00, selective) sends START, a write control byte, device ACK, the address byte, device ACK, a repeated START, a read control byte and device ACK. It then receives 8 data bits, sends NoACK and sends STOP, for a total of 39 bus cycles.
- R5: Mode 1 (2'b01, current address) sends START, a read control byte and device ACK. It then receives 8 data bits, sends NoACK and sends STOP, for a total of 20 bus cycles.
- R6: Mode 2 (2'b10, burst from a chosen address) performs the selective preamble and then reads n words. After each word the master drives ACK (SDA low) except after the last, which gets NoACK. The total is 30+9n bus cycles.
- R7: Mode 3 (2'b11, burst from the current address) reads n words after the current-address preamble, for a total of 11+9n bus cycles.
- R8: In the burst modes a `cmd_count` of zero reads one word. In modes 0 and 1, `cmd_count` is ignored and exactly one word is read.
- R9: If the device answers any control or address byte with NoACK (SDA high in the acknowledge slot), the next bus cycle is STOP, no data is delivered and `done` rises together with `err`. The totals are 11 cycles for a refused first control byte, 20 for a refused address and 30 for a refused read control byte after a selective preamble.
- R10: `done` is a one-clock pulse in the clock after the STOP cycle ends. During that pulse `bus_cycles` holds the number of bus cycles in the transaction, and `err` is 1 only during a failing `done` pulse.
- R11: `cmd_ready` is 0 while a transaction runs. A `cmd_valid` presented then is ignored: the ongoing transaction is unchanged and no further transaction follows it.
- R12: Received words are assembled MSB first. Each one appears on `rd_data` with a one-clock `rd_valid` in phase 0 of the master acknowledge slot that follows it, in address order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when `cmd_ready` is 1 |
| cmd_mode | input | 2 | 00 selective, 01 current, 10 burst at address, 11 burst at current |
| cmd_addr | input | 8 | Word address for modes 00 and 10 |
| cmd_count | input | CNTW | Word count for burst modes (0 reads one) |
| cmd_ready | output | 1 | Idle and able to take a command |
| scl | output | 1 | Serial clock |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Resolved SDA line level |
| rd_valid | output | 1 | One-clock strobe for a received word |
| rd_data | output | 8 | Received word |
| done | output | 1 | One-clock end-of-transaction pulse |
| err | output | 1 | Transaction aborted on a device NoACK (valid with `done`) |
| bus_cycles | output | CYW | Bus cycles used by the last transaction |

## Verification
The hardest case to reach from the ports is a refusal that comes after the device has already accepted the word address: the write control byte and the address byte are acknowledged, but the read control byte after the repeated START is not. The bench's behavioural EEPROM can be told to accept write-direction control bytes and refuse read-direction ones. This leaves its pointer moved, and a later current-address burst must resume from the new position. The same device model also refuses the address byte, or ignores a wrong device address, to cover the two earlier abort points. A second command is injected in the middle of a burst to show that it leaves the waveform untouched.

// File: rtl/i2c_eeprom_reader.sv
module i2c_eeprom_reader #(
  parameter int DIV = 4,
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int CNTW = 8,
  parameter int CYW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_mode,
  input  logic [7:0]      cmd_addr,
  input  logic [CNTW-1:0] cmd_count,
  output logic            cmd_ready,
  output logic            scl,
  output logic            sda_oe,
  input  logic            sda_in,
  output logic            rd_valid,
  output logic [7:0]      rd_data,
  output logic            done,
  output logic            err,
  output logic [CYW-1:0]  bus_cycles
);
  localparam int PW = $clog2(DIV);
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);
  localparam logic [PW-1:0] SAMP = PW'(DIV - 2);

  typedef enum logic [2:0] {S_IDLE, S_START, S_TX, S_DACK, S_RX, S_MACK, S_STOP} state_t;
  typedef enum logic [1:0] {G_CW, G_AD, G_CR} stage_t;

  state_t state;
  stage_t stage;
  logic [PW-1:0]   phase;
  logic [2:0]      bitn;
  logic [7:0]      sh;
  logic [7:0]      addr_q;
  logic [CNTW-1:0] left;
  logic [CYW-1:0]  cyc;
  logic            nak;
  logic            fail;

  wire slot_end = phase == LAST;
  wire mid      = (phase != '0) && (phase != LAST);
  wire last_wd  = left == CNTW'(1);

  assign cmd_ready = state == S_IDLE;

  always_comb begin
    scl    = mid;
    sda_oe = 1'b0;
    case (state)
      S_IDLE:  scl = 1'b1;
      S_START: sda_oe = phase >= SAMP;
      S_TX:    sda_oe = !sh[7];
      S_MACK:  sda_oe = !last_wd;
      S_STOP:  begin scl = phase != '0; sda_oe = phase < SAMP; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      stage      <= G_CW;
      phase      <= '0;
      bitn       <= '0;
      sh         <= '0;
      addr_q     <= '0;
      left       <= '0;
      cyc        <= '0;
      nak        <= 1'b0;
      fail       <= 1'b0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      done       <= 1'b0;
      err        <= 1'b0;
      bus_cycles <= '0;
    end else begin
      done     <= 1'b0;
      err      <= 1'b0;
      rd_valid <= 1'b0;
      if (state == S_IDLE) begin
        phase <= '0;
        if (cmd_valid) begin
          state  <= S_START;
          stage  <= cmd_mode[0] ? G_CR : G_CW;
          addr_q <= cmd_addr;
          left   <= (cmd_mode[1] && cmd_count != '0) ? cmd_count : CNTW'(1);
          cyc    <= '0;
          fail   <= 1'b0;
        end
      end else begin
        phase <= slot_end ? '0 : phase + PW'(1);
        if (phase == SAMP) begin
          if (state == S_RX)   sh  <= {sh[6:0], sda_in};
          if (state == S_DACK) nak <= sda_in;
        end
        if (slot_end) begin
          cyc <= cyc + CYW'(1);
          case (state)
            S_START: begin
              state <= S_TX;
              bitn  <= '0;
              sh    <= {DEV_ADDR, stage == G_CR};
            end
            S_TX: begin
              sh <= {sh[6:0], 1'b0};
              if (bitn == 3'd7) state <= S_DACK;
              else bitn <= bitn + 3'd1;
            end
            S_DACK: begin
              if (nak) begin
                state <= S_STOP;
                fail  <= 1'b1;
              end else begin
                case (stage)
                  G_CW: begin
                    state <= S_TX;
                    stage <= G_AD;
                    sh    <= addr_q;
                    bitn  <= '0;
                  end
                  G_AD: begin
                    state <= S_START;
                    stage <= G_CR;
                  end
                  default: begin
                    state <= S_RX;
                    bitn  <= '0;
                  end
                endcase
              end
            end
            S_RX: begin
              if (bitn == 3'd7) begin
                state    <= S_MACK;
                rd_valid <= 1'b1;
                rd_data  <= sh;
              end else begin
                bitn <= bitn + 3'd1;
              end
            end
            S_MACK: begin
              if (last_wd) begin
                state <= S_STOP;
              end else begin
                state <= S_RX;
                left  <= left - CNTW'(1);
                bitn  <= '0;
              end
            end
            S_STOP: begin
              state      <= S_IDLE;
              done       <= 1'b1;
              err        <= fail;
              bus_cycles <= cyc + CYW'(1);
            end
            default: state <= S_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/i2c_eeprom_reader_chk.sv
module i2c_eeprom_reader_chk #(
  parameter int CYW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cmd_ready,
  input logic           scl,
  input logic           sda_oe,
  input logic           rd_valid,
  input logic           done,
  input logic           err,
  input logic [CYW-1:0] bus_cycles
);
  p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (scl && !sda_oe));

  p_start_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && scl && $past(scl)) |=> !scl);

  p_stop_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_oe) && scl && $past(scl)) |=> (scl && !sda_oe));

  p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_cycles_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (bus_cycles >= CYW'(20)));

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);

  p_valid_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  p_valid_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (!cmd_ready && !done));
endmodule

bind i2c_eeprom_reader i2c_eeprom_reader_chk #(.CYW(CYW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .scl(scl), .sda_oe(sda_oe),
  .rd_valid(rd_valid), .done(done), .err(err), .bus_cycles(bus_cycles)
);

// File: tb/i2c_eeprom_reader_test.sv
module i2c_eeprom_reader_test;
  localparam int DIV = 4;
  localparam logic [6:0] DEV = 7'h50;
  localparam int K_START = 0, K_TX = 1, K_REL = 2, K_MACK = 3, K_STOP = 4;
  localparam int SI = 0, SC = 1, SAC = 2, SAD = 3, SAA = 4, SSD = 5, SMK = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_mode = '0;
  logic [7:0] cmd_addr = '0, cmd_count = '0;
  logic cmd_ready, scl, sda_oe, rd_valid, done, err;
  logic [7:0] rd_data;
  logic [15:0] bus_cycles;
  logic slv_pull = 1'b0;
  wire sda_line = !(sda_oe || slv_pull);

  always #4 clk = ~clk;

  i2c_eeprom_reader #(.DIV(DIV), .DEV_ADDR(DEV), .CNTW(8), .CYW(16)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
    .cmd_addr(cmd_addr), .cmd_count(cmd_count), .cmd_ready(cmd_ready),
    .scl(scl), .sda_oe(sda_oe), .sda_in(sda_line), .rd_valid(rd_valid),
    .rd_data(rd_data), .done(done), .err(err), .bus_cycles(bus_cycles));

  int n_cmp = 0, n_bad = 0;
  logic [7:0] mem [256];
  logic [6:0] slv_dev = DEV;
  bit refuse_addr = 0, refuse_read = 0;
  int st = SI, cnt = 0;
  bit skip = 0, rw = 0, ps = 1, pd = 1;
  logic [7:0] shf = '0, ptr = '0;
  logic [7:0] ref_ptr = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // behavioural EEPROM device on the two-wire bus
  always @(negedge clk) begin
    if (!rst_n) begin
      st = SI; slv_pull = 0; ps = 1; pd = 1; ptr = 0;
    end else begin
      if (scl && ps && pd && !sda_line) begin
        st = SC; cnt = 0; skip = 1;
      end else if (scl && ps && !pd && sda_line) begin
        st = SI; slv_pull = 0;
      end else if (!scl && ps) begin
        case (st)
          SC: if (skip) skip = 0;
              else begin
                shf = {shf[6:0], sda_line}; cnt++;
                if (cnt == 8) begin
                  if (shf[7:1] == slv_dev && !(shf[0] && refuse_read)) begin
                    rw = shf[0]; slv_pull = 1; st = SAC;
                  end else st = SI;
                end
              end
          SAC: begin
            slv_pull = 0;
            if (!rw) begin st = SAD; cnt = 0; end
            else begin st = SSD; cnt = 0; slv_pull = !mem[ptr][7]; end
          end
          SAD: begin
            shf = {shf[6:0], sda_line}; cnt++;
            if (cnt == 8) begin
              if (refuse_addr) st = SI;
              else begin ptr = shf; slv_pull = 1; st = SAA; end
            end
          end
          SAA: begin slv_pull = 0; st = SI; end
          SSD: begin
            cnt++;
            if (cnt < 8) slv_pull = !mem[ptr][7-cnt];
            else begin slv_pull = 0; ptr = ptr + 8'd1; st = SMK; end
          end
          SMK: begin
            if (!sda_line) begin cnt = 0; slv_pull = !mem[ptr][7]; st = SSD; end
            else st = SI;
          end
          default: ;
        endcase
      end
      ps = scl;
      pd = !(sda_oe || slv_pull);
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  // nack: 0 none, 1 first control byte, 2 address byte, 3 read control after address
  task automatic run(input logic [1:0] mode, input logic [7:0] addr, input logic [7:0] count,
                     input int nack, input int poke, input string req, input int exp_cyc);
    int qk[$]; bit qb[$]; logic [7:0] qd[$];
    int words;
    bit sel, fail;
    logic [7:0] cb;
    words = mode[1] ? ((count == 0) ? 1 : int'(count)) : 1;
    sel = !mode[0];
    fail = 0;
    qk.push_back(K_START); qb.push_back(0);
    if (sel) begin
      cb = {DEV, 1'b0};
      for (int i = 7; i >= 0; i--) begin qk.push_back(K_TX); qb.push_back(cb[i]); end
      qk.push_back(K_REL); qb.push_back(0);
      if (nack == 1) fail = 1;
      if (!fail) begin
        for (int i = 7; i >= 0; i--) begin qk.push_back(K_TX); qb.push_back(addr[i]); end
        qk.push_back(K_REL); qb.push_back(0);
        if (nack == 2) fail = 1;
      end
      if (!fail) begin
        ref_ptr = addr;
        qk.push_back(K_START); qb.push_back(0);
      end
    end
    if (!fail) begin
      cb = {DEV, 1'b1};
      for (int i = 7; i >= 0; i--) begin qk.push_back(K_TX); qb.push_back(cb[i]); end
      qk.push_back(K_REL); qb.push_back(0);
      if ((sel && nack == 3) || (!sel && nack != 0)) fail = 1;
    end
    if (!fail)
      for (int w = 0; w < words; w++) begin
        for (int i = 0; i < 8; i++) begin qk.push_back(K_REL); qb.push_back(0); end
        qk.push_back(K_MACK); qb.push_back(w < words - 1);
        qd.push_back(mem[ref_ptr]);
        ref_ptr = ref_ptr + 8'd1;
      end
    qk.push_back(K_STOP); qb.push_back(0);

    cmd_mode = mode; cmd_addr = addr; cmd_count = count; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    for (int s = 0; s < qk.size(); s++)
      for (int p = 0; p < DIV; p++) begin
        bit escl, eoe, ev;
        string lr;
        if (s == poke && p == 0) begin
          cmd_valid = 1; cmd_mode = 2'b00; cmd_addr = 8'h99;
        end else cmd_valid = 0;
        escl = (p != 0) && (p != DIV - 1);
        eoe = 0;
        lr = req;
        case (qk[s])
          K_START: begin eoe = p >= DIV - 2; lr = "R2"; end
          K_TX:    begin eoe = !qb[s]; lr = "R2"; end
          K_MACK:  begin eoe = qb[s]; lr = "R6"; end
          K_STOP:  begin escl = p != 0; eoe = p < DIV - 2; lr = "R2"; end
          default: ;
        endcase
        ev = (qk[s] == K_MACK) && (p == 0);
        chk("R3", scl, escl);
        chk(lr, sda_oe, eoe);
        chk("R12", rd_valid, ev);
        if (ev) chk("R12", rd_data, qd.pop_front());
        chk(req, done, 0);
        chk("R11", cmd_ready, 0);
        @(negedge clk);
      end
    cmd_valid = 0;
    chk(req, done, 1);
    chk(req, err, fail);
    chk(req, bus_cycles, exp_cyc);
    chk("R10", cmd_ready, 1);
    @(negedge clk);
    chk("R10", done, 0);
    chk("R10", err, 0);
    if (poke >= 0)
      for (int i = 0; i < 3 * DIV; i++) begin
        chk("R11", scl, 1);
        chk("R11", sda_oe, 0);
        chk("R11", cmd_ready, 1);
        @(negedge clk);
      end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 53 + 29) ^ (i >> 3));
    repeat (3) @(negedge clk);
    chk("R1", scl, 1); chk("R1", sda_oe, 0); chk("R1", cmd_ready, 1);
    rst_n = 1;
    @(negedge clk);
    chk("R1", scl, 1); chk("R1", sda_oe, 0); chk("R1", cmd_ready, 1);
    chk("R1", done, 0); chk("R1", err, 0); chk("R1", rd_valid, 0);

    run(2'b01, 8'h00, 8'd0, 0, -1, "R5", 20);
    run(2'b00, 8'h3C, 8'd0, 0, -1, "R4", 39);
    run(2'b10, 8'hFE, 8'd3, 0, -1, "R6", 57);
    run(2'b11, 8'h00, 8'd4, 0, 5, "R7", 47);
    run(2'b10, 8'h80, 8'd0, 0, -1, "R8", 39);
    run(2'b00, 8'h10, 8'd5, 0, -1, "R8", 39);
    run(2'b01, 8'h00, 8'd9, 0, -1, "R8", 20);
    slv_dev = 7'h23;
    run(2'b01, 8'h00, 8'd0, 1, -1, "R9", 11);
    run(2'b00, 8'h44, 8'd0, 1, -1, "R9", 11);
    slv_dev = DEV;
    refuse_addr = 1;
    run(2'b00, 8'h44, 8'd0, 2, -1, "R9", 20);
    refuse_addr = 0;
    refuse_read = 1;
    run(2'b00, 8'h55, 8'd0, 3, -1, "R9", 30);
    run(2'b11, 8'h00, 8'd2, 1, -1, "R9", 11);
    refuse_read = 0;
    run(2'b11, 8'h00, 8'd2, 0, 12, "R7", 29);
    summary();
    $finish;
  end
endmodule